// File: doc/BRIEF.md
# Forwarding Start Decision Controller

This block sits beside one ingress port of a packet switch and watches the beats that arrive on that port. Each beat carries a fixed number of bytes, and the stream uses a valid flag and an end-of-packet flag. For every packet the block produces one registered pulse. The pulse means that enough of the packet has arrived for the switch to begin forwarding it.

There are two policies, and a configuration input chooses between them. In cut-through mode the pulse comes as soon as the stacked headers up to the transport layer have arrived. The default threshold is 38 bytes: a 14-byte link header, then a 20-byte network header, then 4 bytes of transport header. In store-and-forward mode the pulse waits for the final beat of the packet.

The block also gives a running count of the bytes received in the current packet. With each pulse it reports the beat number on which the decision was made and the bytes received up to that point.

Top module: `fwd_start_ctrl`

## Requirements
- R1: After reset, `fwd_start`, `fwd_beat_idx`, `fwd_bytes`, `byte_count` and `active_mode` are all zero.
- R2: Each accepted beat (`in_valid` high at a rising edge) adds 8 bytes (DATA_W/8) to `byte_count`. The beat that has `in_last` high returns `byte_count` to 0, and the 0 is visible in the cycle that follows.
- R3: In cut-through mode (`mode_cfg` = 0) the pulse fires on beat ceil(38/8) = 5 of a packet and never on an earlier beat. `fwd_start` is high in the cycle after that beat is accepted.
- R4: In cut-through mode, a packet that ends before beat 5 fires on its last beat.
- R5: In store-and-forward mode (`mode_cfg` = 1) the pulse fires only on the beat that has `in_last` high.
- R6: Every packet yields exactly one `fwd_start` pulse, and that pulse is one cycle wide. This also holds when the threshold beat is the last beat.
- R7: With each pulse, `fwd_beat_idx` gives the 1-based beat number of the trigger and `fwd_bytes` gives that number times 8. Both hold their values until the next pulse.
- R8: `mode_cfg` is sampled only on the first beat of a packet, and `active_mode` shows the sampled value. A change to `mode_cfg` partway through a packet takes effect from the next packet onward.
- R9: A cycle with `in_valid` low changes neither the count nor the trigger position.
- R10: A minimum-size packet of 84 bytes (11 beats) is handled in both modes. Store-and-forward reports beat 11 and 88 bytes, and cut-through reports beat 5 and 40 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_cfg | input | 1 | Forwarding policy: 0 = cut-through, 1 = store-and-forward |
| in_valid | input | 1 | Beat present this cycle |
| in_last | input | 1 | Beat is the final one of its packet |
| fwd_start | output | 1 | One-cycle pulse: forwarding may begin |
| fwd_beat_idx | output | BEAT_W (12) | 1-based beat number of the last trigger |
| fwd_bytes | output | BEAT_W+3 (15) | Bytes received when the last trigger occurred |
| byte_count | output | BEAT_W+3 (15) | Bytes received so far in the current packet |
| active_mode | output | 1 | Policy sampled for the current or most recent packet |

## Verification
The threshold decision and the end-of-packet decision can fall on the same beat. This happens when a cut-through packet is exactly five beats long, and also when any packet is a single beat. In that cycle the trigger must fire exactly once, and the counter must clear, so that the next packet starts fresh. The bench sends these packets and counts every pulse at the falling edge. It then compares the number of pulses, the reported beat and the reported bytes with the values the requirements give. Mode changes partway through a packet are set to land on beat 2 in both directions, and the bench judges them by the trigger beat and by `active_mode`.

// File: rtl/fwd_start_pkg.sv
package fwd_start_pkg;

   typedef enum logic {
      FWD_CUT_THROUGH   = 1'b0,
      FWD_STORE_FORWARD = 1'b1
   } fwd_mode_e;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/fsd_beat_tracker.sv
module fsd_beat_tracker #(
   parameter int unsigned BEAT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_valid,
   input  logic              beat_last,
   output logic              first_beat,
   output logic [BEAT_W-1:0] next_idx,
   output logic [BEAT_W-1:0] beats_seen
);

   localparam logic [BEAT_W-1:0] BEAT_MAX = {BEAT_W{1'b1}};

   logic [BEAT_W-1:0] beat_q;

   assign first_beat = (beat_q == '0);
   assign next_idx   = (beat_q == BEAT_MAX) ? BEAT_MAX : beat_q + 1'b1;
   assign beats_seen = beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (beat_valid) begin
         if (beat_last) beat_q <= '0;
         else           beat_q <= next_idx;
      end
   end

   // R2: the count returns to zero after an end-of-packet beat
   a_r2_clear_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_last) |=> (beat_q == '0));

   // R9: idle cycles leave the count untouched
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_valid |=> $stable(beat_q));

endmodule

// File: rtl/fsd_mode_hold.sv
module fsd_mode_hold
   import fwd_start_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      beat_valid,
   input  logic      first_beat,
   input  fwd_mode_e mode_req,
   output fwd_mode_e eff_mode,
   output fwd_mode_e held_mode
);

   fwd_mode_e mode_q;

   // On the first beat the requested policy applies at once; after that the sampled one does
   assign eff_mode  = (beat_valid && first_beat) ? mode_req : mode_q;
   assign held_mode = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       mode_q <= FWD_CUT_THROUGH;
      else if (beat_valid && first_beat) mode_q <= mode_req;
   end

   // R8: no change of policy inside a packet
   a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !first_beat) |=> $stable(mode_q));

endmodule

// File: rtl/fsd_trigger.sv
module fsd_trigger
   import fwd_start_pkg::*;
#(
   parameter int unsigned BEAT_W     = 12,
   parameter int unsigned THR_BEATS  = 5,
   parameter int unsigned BYTE_SHIFT = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     beat_valid,
   input  logic                     beat_last,
   input  fwd_mode_e                eff_mode,
   input  logic [BEAT_W-1:0]        next_idx,
   output logic                     start_pulse,
   output logic [BEAT_W-1:0]        start_idx,
   output logic [BEAT_W+BYTE_SHIFT-1:0] start_bytes
);

   localparam logic [BEAT_W-1:0] THR_L = BEAT_W'(THR_BEATS);

   logic cut_hit;
   logic fired_q;
   logic trig;

   generate
      if (THR_BEATS <= 1) begin : g_thr_first
         assign cut_hit = 1'b1;
      end else begin : g_thr_cmp
         assign cut_hit = (next_idx >= THR_L);
      end
   endgenerate

   assign trig = beat_valid && !fired_q &&
                 (beat_last || ((eff_mode == FWD_CUT_THROUGH) && cut_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired_q     <= 1'b0;
         start_pulse <= 1'b0;
         start_idx   <= '0;
         start_bytes <= '0;
      end else begin
         start_pulse <= trig;
         if (trig) begin
            start_idx   <= next_idx;
            start_bytes <= {next_idx, {BYTE_SHIFT{1'b0}}};
         end
         if (beat_valid && beat_last) fired_q <= 1'b0;
         else if (trig)               fired_q <= 1'b1;
      end
   end

   // R6: once fired, no further pulse within the packet
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (fired_q && beat_valid) |=> !start_pulse);

   // R3: cut-through never fires before the threshold beat unless the packet ends
   a_r3_not_early: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_last && (next_idx < THR_L)) |=> !start_pulse);

   // R5: store-and-forward waits for the final beat
   a_r5_wait_last: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_last && (eff_mode == FWD_STORE_FORWARD)) |=> !start_pulse);

   // R9: nothing fires on an idle cycle
   a_r9_no_idle_fire: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_valid |=> !start_pulse);

endmodule

// File: rtl/fwd_start_ctrl.sv
module fwd_start_ctrl
   import fwd_start_pkg::*;
#(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned CUT_BYTES = 38,
   parameter int unsigned BEAT_W    = 12,
   localparam int unsigned BPB        = DATA_W / 8,
   localparam int unsigned BYTE_SHIFT = $clog2(BPB),
   localparam int unsigned BYTE_W     = BEAT_W + BYTE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_cfg,
   input  logic              in_valid,
   input  logic              in_last,
   output logic              fwd_start,
   output logic [BEAT_W-1:0] fwd_beat_idx,
   output logic [BYTE_W-1:0] fwd_bytes,
   output logic [BYTE_W-1:0] byte_count,
   output logic              active_mode
);

   localparam int unsigned THR_BEATS = ceil_div(CUT_BYTES, BPB);

   generate
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be a positive multiple of 8");
      end
      if ((1 << BYTE_SHIFT) != BPB) begin : g_bad_pow2
         $error("DATA_W/8 must be a power of two");
      end
      if (CUT_BYTES == 0) begin : g_bad_thr
         $error("CUT_BYTES must be non-zero");
      end
      if (THR_BEATS >= (1 << BEAT_W)) begin : g_bad_beatw
         $error("BEAT_W too narrow for the cut-through threshold");
      end
   endgenerate

   logic              first_beat;
   logic [BEAT_W-1:0] next_idx;
   logic [BEAT_W-1:0] beats_seen;
   fwd_mode_e         eff_mode;
   fwd_mode_e         held_mode;

   fsd_beat_tracker #(.BEAT_W(BEAT_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_valid (in_valid),
      .beat_last  (in_last),
      .first_beat (first_beat),
      .next_idx   (next_idx),
      .beats_seen (beats_seen)
   );

   fsd_mode_hold u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_valid (in_valid),
      .first_beat (first_beat),
      .mode_req   (fwd_mode_e'(mode_cfg)),
      .eff_mode   (eff_mode),
      .held_mode  (held_mode)
   );

   fsd_trigger #(
      .BEAT_W     (BEAT_W),
      .THR_BEATS  (THR_BEATS),
      .BYTE_SHIFT (BYTE_SHIFT)
   ) u_trig (
      .clk         (clk),
      .rst_n       (rst_n),
      .beat_valid  (in_valid),
      .beat_last   (in_last),
      .eff_mode    (eff_mode),
      .next_idx    (next_idx),
      .start_pulse (fwd_start),
      .start_idx   (fwd_beat_idx),
      .start_bytes (fwd_bytes)
   );

   assign byte_count  = {beats_seen, {BYTE_SHIFT{1'b0}}};
   assign active_mode = held_mode;

   // R7: reported bytes agree with the reported beat
   a_r7_bytes_match: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_start |-> (fwd_bytes == BYTE_W'(fwd_beat_idx) * BYTE_W'(BPB)));

   // R7: a pulse never reports beat zero
   a_r7_idx_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_start |-> (fwd_beat_idx != '0));

endmodule

// File: tb/fwd_start_ctrl_tb_top.sv
`timescale 1ns/1ps
module fwd_start_ctrl_tb_top;

   localparam int BEAT_W = 12;
   localparam int BYTE_W = 15;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mode_cfg = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_last = 1'b0;
   logic              fwd_start;
   logic [BEAT_W-1:0] fwd_beat_idx;
   logic [BYTE_W-1:0] fwd_bytes;
   logic [BYTE_W-1:0] byte_count;
   logic              active_mode;

   int n_checks = 0;
   int n_fail   = 0;
   int pulses   = 0;
   int seen_idx = 0;
   int seen_bytes = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fwd_start_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .in_valid(in_valid),
      .in_last(in_last), .fwd_start(fwd_start), .fwd_beat_idx(fwd_beat_idx),
      .fwd_bytes(fwd_bytes), .byte_count(byte_count), .active_mode(active_mode)
   );

   always @(negedge clk) begin
      if (rst_n && fwd_start) begin
         pulses     <= pulses + 1;
         seen_idx   <= int'(fwd_beat_idx);
         seen_bytes <= int'(fwd_bytes);
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Send one packet; optional policy switch on beat sw_at; optional idle gap between beats
   task automatic send_pkt(input int nbeats, input bit mode0, input int sw_at,
                           input bit mode1, input bit gaps,
                           input int exp_idx, input bit exp_mode, input string req);
      int p0;
      @(posedge clk); #1;
      p0 = pulses;
      mode_cfg = mode0;
      for (int b = 1; b <= nbeats; b++) begin
         if (gaps && b > 1) begin
            in_valid = 1'b0; in_last = 1'b0;
            @(posedge clk); #1;
         end
         if (b == sw_at) mode_cfg = mode1;
         in_valid = 1'b1;
         in_last  = (b == nbeats);
         @(posedge clk); #1;
      end
      in_valid = 1'b0; in_last = 1'b0;
      @(negedge clk); #1;
      check(pulses - p0 == 1, {req, " pulse count"}, pulses - p0, 1);
      check(seen_idx == exp_idx, {req, " trigger beat"}, seen_idx, exp_idx);
      check(seen_bytes == exp_idx * 8, {req, " trigger bytes"}, seen_bytes, exp_idx * 8);
      check(byte_count == 0, {req, " R2 count cleared"}, int'(byte_count), 0);
      check(active_mode == exp_mode, {req, " R8 sampled mode"}, int'(active_mode), int'(exp_mode));
   endtask

   task automatic t_reset;
      check(fwd_start == 1'b0, "R1 fwd_start", int'(fwd_start), 0);
      check(fwd_beat_idx == 0, "R1 fwd_beat_idx", int'(fwd_beat_idx), 0);
      check(fwd_bytes == 0, "R1 fwd_bytes", int'(fwd_bytes), 0);
      check(byte_count == 0, "R1 byte_count", int'(byte_count), 0);
      check(active_mode == 1'b0, "R1 active_mode", int'(active_mode), 0);
   endtask

   // R2, R9: partial count, then idle cycles, then the count is unchanged
   task automatic t_count_idle;
      int p0;
      @(posedge clk); #1;
      p0 = pulses;
      mode_cfg = 1'b1;
      for (int b = 1; b <= 3; b++) begin
         in_valid = 1'b1; in_last = 1'b0;
         @(posedge clk); #1;
      end
      in_valid = 1'b0;
      @(negedge clk);
      check(byte_count == 24, "R2 three beats", int'(byte_count), 24);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(byte_count == 24, "R9 idle keeps count", int'(byte_count), 24);
      check(pulses == p0, "R9 no pulse while idle", pulses - p0, 0);
      #1;
      in_valid = 1'b1; in_last = 1'b1;
      @(posedge clk); #1;
      in_valid = 1'b0; in_last = 1'b0;
      @(negedge clk); #1;
      check(seen_idx == 4, "R5 fire on last after idle", seen_idx, 4);
      check(byte_count == 0, "R2 cleared", int'(byte_count), 0);
   endtask

   task automatic t_pulse_width;
      // R6: pulse must be gone one cycle after it appears
      @(posedge clk); #1;
      mode_cfg = 1'b0;
      for (int b = 1; b <= 7; b++) begin
         in_valid = 1'b1; in_last = (b == 7);
         @(posedge clk); #1;
         if (b == 5) check(fwd_start == 1'b1, "R6 pulse after beat 5", int'(fwd_start), 1);
         if (b == 6) check(fwd_start == 1'b0, "R6 pulse one cycle", int'(fwd_start), 0);
      end
      in_valid = 1'b0; in_last = 1'b0;
      @(negedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      send_pkt(11, 1'b0, 0, 1'b0, 1'b0, 5,  1'b0, "R3 R10 cut 84B");
      send_pkt(11, 1'b1, 0, 1'b1, 1'b0, 11, 1'b1, "R5 R10 saf 84B");
      send_pkt(3,  1'b0, 0, 1'b0, 1'b0, 3,  1'b0, "R4 cut short");
      send_pkt(5,  1'b0, 0, 1'b0, 1'b0, 5,  1'b0, "R6 threshold on last");
      send_pkt(1,  1'b0, 0, 1'b0, 1'b0, 1,  1'b0, "R6 single beat cut");
      send_pkt(1,  1'b1, 0, 1'b1, 1'b0, 1,  1'b1, "R6 single beat saf");
      send_pkt(11, 1'b0, 2, 1'b1, 1'b0, 5,  1'b0, "R8 cut then switch");
      send_pkt(11, 1'b1, 0, 1'b1, 1'b0, 11, 1'b1, "R8 next pkt saf");
      send_pkt(11, 1'b1, 2, 1'b0, 1'b0, 11, 1'b1, "R8 saf then switch");
      send_pkt(9,  1'b0, 0, 1'b0, 1'b1, 5,  1'b0, "R9 R3 cut with gaps");
      send_pkt(6,  1'b1, 0, 1'b1, 1'b1, 6,  1'b1, "R9 R5 saf with gaps");
      t_count_idle();
      t_pulse_width();
      check(seen_idx == 5 && seen_bytes == 40, "R7 held after pulse", seen_idx, 5);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule